// File: doc/BRIEF.md
# Store-to-Load Forwarding Queue

This block keeps a small circular queue of in-flight stores and answers forwarding lookups from a load pipeline. Each slot remembers a store's virtual and physical line address, the bytes it writes inside a 16-byte line, its data, and whether the address and the data are known yet. Stores claim slots at the tail, write their address and data through separate write ports, and leave from the head through a retire port.

A load presents its line addresses, a 16-bit byte mask and a one-bit-per-slot mask of the stores older than itself. One cycle later the unit gives an early byte mask and an early data-not-ready flag. One more cycle later it gives the forwarded bytes with their valid bits, data-not-ready and address-not-ready indications, each with the slot index of the youngest store that blocks forwarding, and a flag that is raised when virtual and physical matching disagree.

Top module: `stfwd_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_idx` is 0, and every forwarding output, flag and index is 0.
- R2: A pulse on `alloc_en` claims slot `alloc_idx`, which then advances by one modulo 8. The pulse is ignored when 8 slots are live. `retire_en` frees the oldest live slot and is ignored when the queue is empty.
- R3: An address write (`aw_en`) becomes visible to lookups in two steps. A lookup presented in the same cycle as the write still sees the slot's address as unknown. A lookup presented in the next cycle sees the written address and mask.
- R4: A slot matches a lookup only when it is live, its bit in `q_older` is set (bit i is slot i), its address is known, its line address equals the lookup's line address, and its byte mask shares a set bit with `q_mask`.
- R5: For each byte i in `q_mask` (bit i stands for data bits 8i+7..8i), the unit takes the youngest virtually matching store that covers byte i. If that store's data is known, `f2_mask[i]` is 1 and the byte holds its data. In every other case `f2_mask[i]` is 0 and the byte is 0.
- R6: `f1_mask` is the cycle after a lookup and carries the byte mask that `f2_mask` reports one cycle later for the same lookup.
- R7: A data write (`dw_en`) makes a slot's data known from the next cycle. When any virtually matching store has unknown data, `f1_data_wait` is raised one cycle after the lookup and `f2_data_wait` two cycles after. `f2_data_wait_idx` then holds the youngest such slot.
- R8: When a live older slot's address is not yet known, `f2_addr_wait` is raised two cycles after the lookup and `f2_addr_wait_idx` holds the youngest such slot.
- R9: `f2_mismatch` is raised two cycles after a lookup when the set of slots that match on virtual line address differs from the set that match on physical line address. Forwarding follows the virtual match.
- R10: A retired slot takes part in no match, no wait flag and no mismatch.
- R11: In a cycle that follows no lookup, the early outputs are 0. Two cycles after no lookup, all second-stage outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_en | input | 1 | Claim the tail slot for a new store |
| alloc_idx | output | 3 | Slot the next claim will take |
| retire_en | input | 1 | Free the oldest live slot |
| aw_en | input | 1 | Address and byte-mask write request |
| aw_idx | input | 3 | Slot for the address write |
| aw_vline | input | 35 | Virtual line address (address above the 16-byte offset) |
| aw_pline | input | 32 | Physical line address |
| aw_mask | input | 16 | Store byte mask |
| dw_en | input | 1 | Data write request |
| dw_idx | input | 3 | Slot for the data write |
| dw_data | input | 128 | Store data, byte i in bits 8i+7..8i |
| q_valid | input | 1 | Lookup present |
| q_vline | input | 35 | Lookup virtual line address |
| q_pline | input | 32 | Lookup physical line address |
| q_mask | input | 16 | Lookup byte mask |
| q_older | input | 8 | Slots older than the load |
| f1_mask | output | 16 | Early forward byte mask |
| f1_data_wait | output | 1 | Early data-not-ready |
| f2_mask | output | 16 | Forward byte valid bits |
| f2_data | output | 128 | Forwarded bytes |
| f2_data_wait | output | 1 | Data-not-ready |
| f2_data_wait_idx | output | 3 | Youngest slot with unknown data |
| f2_addr_wait | output | 1 | Address-not-ready |
| f2_addr_wait_idx | output | 3 | Youngest slot with unknown address |
| f2_mismatch | output | 1 | Virtual and physical matches differ |

## Verification
The hardest situation to reach is a lookup that crosses the address-write pipeline: the write has been requested but not yet committed. The same lookup must report address-not-ready, and the lookup one cycle later must see the address. The directed part of the stimulus places the write and the lookups in exactly those cycles. It also builds overlapping stores whose youngest-per-byte choice mixes two slots, and it stores a physical line that disagrees with the virtual one. A long random phase then works on two lines only, with frequent claims, retires and wraps, and a reference model checks every output on every clock.

// File: rtl/stfwd_queue.sv
module stfwd_queue #(
  parameter int ENTRIES = 8,
  parameter int VL_W    = 35,
  parameter int PL_W    = 32,
  parameter int NBYTES  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  output logic [$clog2(ENTRIES)-1:0] alloc_idx,
  input  logic                       retire_en,
  input  logic                       aw_en,
  input  logic [$clog2(ENTRIES)-1:0] aw_idx,
  input  logic [VL_W-1:0]            aw_vline,
  input  logic [PL_W-1:0]            aw_pline,
  input  logic [NBYTES-1:0]          aw_mask,
  input  logic                       dw_en,
  input  logic [$clog2(ENTRIES)-1:0] dw_idx,
  input  logic [8*NBYTES-1:0]        dw_data,
  input  logic                       q_valid,
  input  logic [VL_W-1:0]            q_vline,
  input  logic [PL_W-1:0]            q_pline,
  input  logic [NBYTES-1:0]          q_mask,
  input  logic [ENTRIES-1:0]         q_older,
  output logic [NBYTES-1:0]          f1_mask,
  output logic                       f1_data_wait,
  output logic [NBYTES-1:0]          f2_mask,
  output logic [8*NBYTES-1:0]        f2_data,
  output logic                       f2_data_wait,
  output logic [$clog2(ENTRIES)-1:0] f2_data_wait_idx,
  output logic                       f2_addr_wait,
  output logic [$clog2(ENTRIES)-1:0] f2_addr_wait_idx,
  output logic                       f2_mismatch
);
  localparam int IW = $clog2(ENTRIES);
  localparam int DW = 8 * NBYTES;

  logic [ENTRIES-1:0] live, a_ok, d_ok;
  logic [VL_W-1:0]    e_vl  [ENTRIES];
  logic [PL_W-1:0]    e_pl  [ENTRIES];
  logic [NBYTES-1:0]  e_bm  [ENTRIES];
  logic [DW-1:0]      e_dat [ENTRIES];
  logic [IW:0]        head, tail, used;
  logic               do_alloc, do_ret;

  logic               pw_en;
  logic [IW-1:0]      pw_idx;
  logic [VL_W-1:0]    pw_vl;
  logic [PL_W-1:0]    pw_pl;
  logic [NBYTES-1:0]  pw_bm;

  logic               s1_v;
  logic [VL_W-1:0]    s1_vl;
  logic [PL_W-1:0]    s1_pl;
  logic [NBYTES-1:0]  s1_mask;
  logic [ENTRIES-1:0] s1_old;

  logic [ENTRIES-1:0] vm, pm, awv;
  logic [NBYTES-1:0]  hit, ok, fm;
  logic [DW-1:0]      fd;
  logic               dwait, await_;
  logic [IW-1:0]      dwi, awi;

  assign used      = tail - head;
  assign do_alloc  = alloc_en && (used != (IW+1)'(ENTRIES));
  assign do_ret    = retire_en && (used != '0);
  assign alloc_idx = tail[IW-1:0];

  always_comb begin
    logic elig;
    vm = '0; pm = '0; awv = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      elig   = s1_v && live[i] && s1_old[i];
      awv[i] = elig && !a_ok[i];
      vm[i]  = elig && a_ok[i] && (e_vl[i] == s1_vl) && |(e_bm[i] & s1_mask);
      pm[i]  = elig && a_ok[i] && (e_pl[i] == s1_pl) && |(e_bm[i] & s1_mask);
    end
  end

  always_comb begin
    logic [IW-1:0] slot;
    hit = '0; ok = '0; fd = '0; fm = '0;
    dwait = 1'b0; dwi = '0; await_ = 1'b0; awi = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      slot = head[IW-1:0] + IW'(k);
      if (vm[slot] && !d_ok[slot]) begin dwait = 1'b1; dwi = slot; end
      if (awv[slot]) begin await_ = 1'b1; awi = slot; end
      for (int b = 0; b < NBYTES; b++)
        if (vm[slot] && e_bm[slot][b]) begin
          hit[b] = 1'b1;
          ok[b]  = d_ok[slot];
          fd[8*b +: 8] = e_dat[slot][8*b +: 8];
        end
    end
    for (int b = 0; b < NBYTES; b++) begin
      fm[b] = hit[b] && ok[b] && s1_mask[b];
      if (!fm[b]) fd[8*b +: 8] = '0;
    end
  end

  assign f1_mask      = fm;
  assign f1_data_wait = dwait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0; a_ok <= '0; d_ok <= '0;
      head <= '0; tail <= '0;
      pw_en <= 1'b0; s1_v <= 1'b0;
      f2_mask <= '0; f2_data <= '0;
      f2_data_wait <= 1'b0; f2_data_wait_idx <= '0;
      f2_addr_wait <= 1'b0; f2_addr_wait_idx <= '0;
      f2_mismatch <= 1'b0;
    end else begin
      if (do_ret) live[head[IW-1:0]] <= 1'b0;
      if (do_alloc) begin
        live[tail[IW-1:0]] <= 1'b1;
        a_ok[tail[IW-1:0]] <= 1'b0;
        d_ok[tail[IW-1:0]] <= 1'b0;
      end
      if (pw_en) a_ok[pw_idx] <= 1'b1;
      if (dw_en) d_ok[dw_idx] <= 1'b1;
      head  <= head + (IW+1)'(do_ret);
      tail  <= tail + (IW+1)'(do_alloc);
      pw_en <= aw_en;
      s1_v  <= q_valid;
      f2_mask          <= fm;
      f2_data          <= fd;
      f2_data_wait     <= dwait;
      f2_data_wait_idx <= dwi;
      f2_addr_wait     <= await_;
      f2_addr_wait_idx <= awi;
      f2_mismatch      <= (vm != pm);
    end
  end

  always_ff @(posedge clk) begin
    pw_idx  <= aw_idx;
    pw_vl   <= aw_vline;
    pw_pl   <= aw_pline;
    pw_bm   <= aw_mask;
    s1_vl   <= q_vline;
    s1_pl   <= q_pline;
    s1_mask <= q_mask;
    s1_old  <= q_older;
    if (pw_en) begin
      e_vl[pw_idx] <= pw_vl;
      e_pl[pw_idx] <= pw_pl;
      e_bm[pw_idx] <= pw_bm;
    end
    if (dw_en) e_dat[dw_idx] <= dw_data;
  end
endmodule

module stfwd_queue_chk #(
  parameter int ENTRIES = 8,
  parameter int NBYTES  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_en,
  input logic [$clog2(ENTRIES)-1:0] alloc_idx,
  input logic                       q_valid,
  input logic [NBYTES-1:0]          q_mask,
  input logic [ENTRIES-1:0]         q_older,
  input logic [NBYTES-1:0]          f1_mask,
  input logic                       f1_data_wait,
  input logic [NBYTES-1:0]          f2_mask,
  input logic [8*NBYTES-1:0]        f2_data,
  input logic                       f2_data_wait,
  input logic [$clog2(ENTRIES)-1:0] f2_data_wait_idx,
  input logic                       f2_addr_wait,
  input logic [$clog2(ENTRIES)-1:0] f2_addr_wait_idx,
  input logic                       f2_mismatch
);
  logic [8*NBYTES-1:0] byte_en;
  for (genvar b = 0; b < NBYTES; b++) begin : g_be
    assign byte_en[8*b +: 8] = {8{f2_mask[b]}};
  end

  assert_fast_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(q_valid) |-> (f1_mask & ~$past(q_mask)) == '0);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(q_valid) |-> (f1_mask == '0) && !f1_data_wait);

  assert_unfwd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_data & ~byte_en) == '0);

  assert_alloc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(alloc_en) |-> $stable(alloc_idx));

  assert_addr_wait_older_R8: assert property (@(posedge clk) disable iff (!rst_n)
    f2_addr_wait |-> (($past(q_older, 2) >> f2_addr_wait_idx) & ENTRIES'(1)) != '0);

  assert_data_wait_older_R7: assert property (@(posedge clk) disable iff (!rst_n)
    f2_data_wait |-> (($past(q_older, 2) >> f2_data_wait_idx) & ENTRIES'(1)) != '0);

  assert_mismatch_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    f2_mismatch |-> $past(q_valid, 2));
endmodule

bind stfwd_queue stfwd_queue_chk #(.ENTRIES(ENTRIES), .NBYTES(NBYTES)) u_chk (.*);

// File: tb/sim_stfwd_queue.sv
`timescale 1ns/1ps
module sim_stfwd_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic alloc_en = 0, retire_en = 0, aw_en = 0, dw_en = 0, q_valid = 0;
  logic [2:0] alloc_idx, aw_idx = 0, dw_idx = 0;
  logic [34:0] aw_vline = 0, q_vline = 0;
  logic [31:0] aw_pline = 0, q_pline = 0;
  logic [15:0] aw_mask = 0, q_mask = 0;
  logic [127:0] dw_data = 0;
  logic [7:0] q_older = 0;
  logic [15:0] f1_mask, f2_mask;
  logic [127:0] f2_data;
  logic f1_data_wait, f2_data_wait, f2_addr_wait, f2_mismatch;
  logic [2:0] f2_data_wait_idx, f2_addr_wait_idx;

  stfwd_queue u0 (.*);

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit m_live[8], m_aok[8], m_dok[8];
  logic [34:0] m_vl[8];
  logic [31:0] m_pl[8];
  logic [15:0] m_bm[8];
  logic [127:0] m_dat[8];
  int m_head = 0, m_used = 0;
  bit p_en; int p_idx; logic [34:0] p_vl; logic [31:0] p_pl; logic [15:0] p_bm;
  bit ms_v; logic [34:0] ms_vl; logic [31:0] ms_pl; logic [15:0] ms_mask; logic [7:0] ms_old;
  logic [15:0] o_mask; logic [127:0] o_data; bit o_dw, o_aw, o_mm; int o_dwi, o_awi;
  logic [15:0] x2_mask; logic [127:0] x2_data; bit x2_dw, x2_aw, x2_mm; int x2_dwi, x2_awi;
  logic [15:0] x1_mask; bit x1_dw;

  task automatic eval_model();
    logic [7:0] vmv, pmv;
    bit el;
    int s;
    vmv = 0; pmv = 0;
    o_mask = 0; o_data = 0; o_dw = 0; o_aw = 0; o_dwi = 0; o_awi = 0;
    for (int e = 0; e < 8; e++) begin
      el = ms_v && m_live[e] && ms_old[e];
      if (el && m_aok[e] && (m_bm[e] & ms_mask) != 0) begin
        vmv[e] = (m_vl[e] == ms_vl);
        pmv[e] = (m_pl[e] == ms_pl);
      end
    end
    for (int k = 7; k >= 0; k--) begin
      s = (m_head + k) % 8;
      if (!o_aw && ms_v && m_live[s] && ms_old[s] && !m_aok[s]) begin o_aw = 1; o_awi = s; end
      if (!o_dw && vmv[s] && !m_dok[s]) begin o_dw = 1; o_dwi = s; end
    end
    for (int b = 0; b < 16; b++)
      for (int k = 7; k >= 0; k--) begin
        s = (m_head + k) % 8;
        if (vmv[s] && m_bm[s][b]) begin
          if (m_dok[s] && ms_mask[b]) begin
            o_mask[b] = 1;
            o_data[8*b +: 8] = m_dat[s][8*b +: 8];
          end
          break;
        end
      end
    o_mm = (vmv != pmv);
  endtask

  task automatic model_edge();
    int t;
    eval_model();
    x2_mask = o_mask; x2_data = o_data; x2_dw = o_dw; x2_dwi = o_dwi;
    x2_aw = o_aw; x2_awi = o_awi; x2_mm = o_mm;
    if (retire_en && m_used > 0) begin m_live[m_head] = 0; m_head = (m_head + 1) % 8; m_used--; end
    else if (alloc_en && m_used < 8) begin end
    if (alloc_en && (m_used + ((retire_en && m_used_before_ret()) ? 1 : 0)) < 8) begin end
    t = 0;
  endtask

  // retire/alloc decisions both use the occupancy before the edge
  int occ_before;
  function automatic bit m_used_before_ret();
    return 1'b0;
  endfunction

  task automatic step_model();
    int tl;
    eval_model();
    x2_mask = o_mask; x2_data = o_data; x2_dw = o_dw; x2_dwi = o_dwi;
    x2_aw = o_aw; x2_awi = o_awi; x2_mm = o_mm;
    occ_before = m_used;
    tl = (m_head + m_used) % 8;
    if (retire_en && occ_before > 0) begin
      m_live[m_head] = 0; m_head = (m_head + 1) % 8; m_used--;
    end
    if (alloc_en && occ_before < 8) begin
      m_live[tl] = 1; m_aok[tl] = 0; m_dok[tl] = 0; m_used++;
    end
    if (p_en) begin m_vl[p_idx] = p_vl; m_pl[p_idx] = p_pl; m_bm[p_idx] = p_bm; m_aok[p_idx] = 1; end
    if (dw_en) begin m_dat[dw_idx] = dw_data; m_dok[dw_idx] = 1; end
    p_en = aw_en; p_idx = aw_idx; p_vl = aw_vline; p_pl = aw_pline; p_bm = aw_mask;
    ms_v = q_valid; ms_vl = q_vline; ms_pl = q_pline; ms_mask = q_mask; ms_old = q_older;
    eval_model();
    x1_mask = o_mask; x1_dw = o_dw;
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 alloc_idx", 128'(alloc_idx), 128'((m_head + m_used) % 8));
    chk("R6 f1_mask", 128'(f1_mask), 128'(x1_mask));
    chk("R7 f1_data_wait", 128'(f1_data_wait), 128'(x1_dw));
    chk("R5 f2_mask", 128'(f2_mask), 128'(x2_mask));
    chk("R5 f2_data", f2_data, x2_data);
    chk("R7 f2_data_wait", 128'(f2_data_wait), 128'(x2_dw));
    chk("R7 f2_data_wait_idx", 128'(f2_data_wait_idx), 128'(x2_dwi));
    chk("R8 f2_addr_wait", 128'(f2_addr_wait), 128'(x2_aw));
    chk("R8 f2_addr_wait_idx", 128'(f2_addr_wait_idx), 128'(x2_awi));
    chk("R9 f2_mismatch", 128'(f2_mismatch), 128'(x2_mm));
  endtask

  task automatic tick();
    @(posedge clk);
    step_model();
    @(negedge clk);
    compare_all();
  endtask

  task automatic clr();
    alloc_en = 0; retire_en = 0; aw_en = 0; dw_en = 0; q_valid = 0;
  endtask

  task automatic lookup(logic [34:0] vl, logic [31:0] pl, logic [15:0] mk, logic [7:0] old);
    q_valid = 1; q_vline = vl; q_pline = pl; q_mask = mk; q_older = old;
    tick();
    q_valid = 0;
    tick();
  endtask

  task automatic wr(int idx, logic [34:0] vl, logic [31:0] pl, logic [15:0] mk, logic [127:0] d);
    aw_en = 1; aw_idx = 3'(idx); aw_vline = vl; aw_pline = pl; aw_mask = mk;
    dw_en = 1; dw_idx = 3'(idx); dw_data = d;
    tick();
    aw_en = 0; dw_en = 0;
    tick();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  localparam logic [34:0] LV = 35'h123_4560;
  localparam logic [31:0] LP = 32'h0ABC_DE00;
  localparam logic [127:0] D0 = 128'h00112233445566778899AABBCCDDEEFF;
  localparam logic [127:0] D2 = 128'hF0F1F2F3F4F5F6F7F8F9FAFBFCFDFEFF;
  localparam logic [127:0] D3 = 128'h5555555555555555555555555555AA77;

  initial begin
    logic [127:0] ex;
    p_en = 0; ms_v = 0;
    for (int i = 0; i < 8; i++) begin m_live[i] = 0; m_aok[i] = 0; m_dok[i] = 0; end
    x1_mask = 0; x1_dw = 0; x2_mask = 0; x2_data = 0; x2_dw = 0; x2_dwi = 0;
    x2_aw = 0; x2_awi = 0; x2_mm = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 alloc_idx", 128'(alloc_idx), 0);
    chk("R1 f1_mask", 128'(f1_mask), 0);
    chk("R1 f2 flags", 128'({f2_mask, f2_data_wait, f2_addr_wait, f2_mismatch, f2_data_wait_idx, f2_addr_wait_idx}), 0);
    chk("R1 f2_data", f2_data, 0);
    rst_n = 1;
    tick();

    // R3 / R7: write pipeline versus lookups
    alloc_en = 1; tick(); alloc_en = 0;
    aw_en = 1; aw_idx = 0; aw_vline = LV; aw_pline = LP; aw_mask = 16'h00FF;
    q_valid = 1; q_vline = LV; q_pline = LP; q_mask = 16'hFFFF; q_older = 8'h01;
    tick();
    aw_en = 0;
    tick();
    chk("R3 address still unknown", 128'(f2_addr_wait), 1);
    chk("R7 early data wait", 128'(f1_data_wait), 1);
    dw_en = 1; dw_idx = 0; dw_data = D0;
    tick();
    chk("R3 address visible", 128'(f2_addr_wait), 0);
    chk("R7 data wait", 128'(f2_data_wait), 1);
    chk("R7 data wait idx", 128'(f2_data_wait_idx), 0);
    chk("R6 early mask", 128'(f1_mask), 128'(16'h00FF));
    dw_en = 0; q_valid = 0;
    tick();
    chk("R5 single store mask", 128'(f2_mask), 128'(16'h00FF));
    chk("R5 single store data", f2_data, {64'h0, D0[63:0]});
    chk("R11 idle early mask", 128'(f1_mask), 0);

    // R5 youngest store per byte
    alloc_en = 1; tick(); alloc_en = 0;
    wr(1, LV, LP, 16'h0F0F, D2);
    lookup(LV, LP, 16'hFFFF, 8'h03);
    ex = 0;
    for (int b = 0; b < 12; b++)
      ex[8*b +: 8] = (b < 4 || b >= 8) ? D2[8*b +: 8] : D0[8*b +: 8];
    chk("R5 merged mask", 128'(f2_mask), 128'(16'h0FFF));
    chk("R5 merged data", f2_data, ex);
    lookup(LV, LP, 16'hFFFF, 8'h01);
    chk("R4 older mask limits search", 128'(f2_mask), 128'(16'h00FF));

    // R4 non-matching lookups
    lookup(LV + 1, LP + 1, 16'hFFFF, 8'h03);
    chk("R4 other line", 128'({f2_mask, f2_data_wait, f2_mismatch}), 0);
    lookup(LV, LP, 16'hF000, 8'h03);
    chk("R4 no byte overlap", 128'({f2_mask, f2_data_wait, f2_mismatch}), 0);

    // R9 virtual/physical disagreement
    alloc_en = 1; tick(); alloc_en = 0;
    wr(2, LV, LP + 5, 16'h0001, D3);
    lookup(LV, LP, 16'hFFFF, 8'h07);
    chk("R9 mismatch raised", 128'(f2_mismatch), 1);
    chk("R9 virtual match forwards", 128'(f2_data[7:0]), 128'(8'h77));

    // R8 unknown address
    alloc_en = 1; tick(); alloc_en = 0;
    lookup(LV, LP, 16'hFFFF, 8'h0F);
    chk("R8 addr wait", 128'(f2_addr_wait), 1);
    chk("R8 addr wait idx", 128'(f2_addr_wait_idx), 3);
    lookup(LV, LP, 16'hFFFF, 8'h07);
    chk("R8 younger slot excluded", 128'(f2_addr_wait), 0);

    // R2 full queue ignores claims
    alloc_en = 1; repeat (4) tick();
    tick(); alloc_en = 0;
    chk("R2 claim ignored when full", 128'(alloc_idx), 0);

    // R10 retired slot never matches
    retire_en = 1; tick(); retire_en = 0;
    lookup(LV, LP, 16'hFFFF, 8'h01);
    chk("R10 retired slot", 128'({f2_mask, f2_data_wait, f2_addr_wait, f2_mismatch}), 0);
    retire_en = 1; repeat (8) tick(); retire_en = 0;
    alloc_en = 1; tick(); alloc_en = 0;
    chk("R2 retire ignored when empty", 128'(alloc_idx), 1);
    chk("R11 idle second stage", 128'({f2_mask, f2_data_wait, f2_addr_wait, f2_mismatch}), 0);

    // random phase on two lines
    for (int c = 0; c < 4000; c++) begin
      int ln;
      alloc_en  = ($urandom % 3) == 0;
      retire_en = ($urandom % 4) == 0;
      aw_en = ($urandom % 3) == 0;
      aw_idx = 3'($urandom);
      ln = $urandom % 2;
      aw_vline = LV + 35'(ln);
      aw_pline = (($urandom % 10) == 0) ? LP + 32'(1 - ln) : LP + 32'(ln);
      aw_mask = (($urandom % 3) == 0) ? 16'($urandom)
              : 16'((32'h1 << ($urandom % 5)) - 1) << ($urandom % 16);
      dw_en = ($urandom % 3) == 0;
      dw_idx = 3'($urandom);
      dw_data = {$urandom, $urandom, $urandom, $urandom};
      q_valid = ($urandom % 2) == 0;
      ln = $urandom % 2;
      q_vline = LV + 35'(ln);
      q_pline = LP + 32'(ln);
      q_mask = (($urandom % 2) == 0) ? 16'hFFFF : 16'($urandom);
      q_older = 8'($urandom);
      tick();
    end
    clr();
    tick();
    report();
  end
endmodule